// File: doc/BRIEF.md
# Serial Character Time Generator

This block times one serial character for a UART-style port. It keeps a copy of the frame-shape settings (short character, parity on, two stop bits, prescaler select) and the 8-bit bit-rate value, and from them it works out how many input clocks one character takes on the line. Two independent timers run that length. The transmit timer gives a single-cycle end-of-character pulse when a character would have finished leaving the line. The receive timer holds a ready level low after each received byte, so reception stays blocked for one character time.

The length is computed from the settings and not taken from a fixed divider. Bits per character times 32 gives the clocks per character at unit rate. That figure is scaled by the rate value and then by a power-of-four prescaler. The new settings take effect only when the load strobe accepts them. Each timer is a two-state machine. In SPAN_IDLE it waits, and a start strobe moves it to SPAN_RUN (transition "launch"). In SPAN_RUN it counts down, and a further start reloads it ("relaunch"). When the count reaches zero it raises its expiry output and returns to SPAN_IDLE ("expire").

Top module: `char_time_gen`

## Requirements
- R1: Bits per character equal 8, minus 1 when `mode_short`=1, plus 1 when `mode_parity`=1, plus 1 for the start/stop overhead, plus 1 more when `mode_two_stop`=1.
- R2: The character time in clocks is bits × 32 × `bit_rate` × 4^`clk_div_sel`, where `clk_div_sel` = 0,1,2,3 gives 1,4,16,64. The internal count is wide enough for the largest product with no overflow.
- R3: Settings are taken only in a cycle where `cfg_load`=1. A change on the setting inputs without `cfg_load` has no effect on later character times.
- R4: After `tx_start` is sampled high at edge E, `tx_char_end` is high for exactly one cycle: the cycle after edge E+T−1, where T is the character time.
- R5: A `tx_start` while the transmit timer runs restarts a full character time from that strobe. The earlier run produces no pulse.
- R6: After `rx_start` is sampled at edge E, `rx_ready` is low from edge E until edge E+T and high again from then on.
- R7: A `bit_rate` of 0 gives a character time of one clock.
- R8: The transmit and receive timers are independent. Started together, both finish on their own schedule.
- R9: After reset `rx_ready`=1 and `tx_char_end`=0. The settings reset to rate 255 with all mode bits 0, which is a 9 × 32 × 255 = 73440-clock character.
- R10: Settings accepted while a timer runs do not change that run. They apply from the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Accept the setting inputs this cycle |
| mode_short | input | 1 | 1 = one data bit fewer |
| mode_parity | input | 1 | 1 = parity bit present |
| mode_two_stop | input | 1 | 1 = two stop bits |
| clk_div_sel | input | 2 | Prescaler select, 4^value |
| bit_rate | input | 8 | Bit-rate multiplier |
| tx_start | input | 1 | Transmit character started |
| rx_start | input | 1 | Byte received |
| tx_char_end | output | 1 | One-cycle end-of-character pulse |
| rx_ready | output | 1 | High when reception is not blocked |

## Verification
Assertions check on every cycle that the held length changes only on a load strobe, and that a zero rate gives length one. They also check that each timer loads length−1 on a start, counts down by one with no start, and drops to idle after expiring with no second pulse. Only the bench scenarios can show that the computed lengths match the frame-shape formula for the different mode and prescaler mixes. The same holds for the exact cycle of the pulse and of the return of the ready level, for restart, for overlapping timers, and for settings loaded during a run.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
    typedef enum logic {
        SPAN_IDLE = 1'b0,
        SPAN_RUN  = 1'b1
    } span_state_t;

    localparam int BITS_W = 4;
    localparam int UNIT_SHIFT = 5;
endpackage

// File: rtl/ctg_char_calc.sv
module ctg_char_calc
    import ctg_pkg::*;
#(
    parameter int RATE_W = 8,
    parameter int SEL_W  = 2,
    parameter int CNT_W  = 24
) (
    input  logic              short_chr,
    input  logic              parity_on,
    input  logic              two_stop,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic [RATE_W-1:0] rate,
    output logic [CNT_W-1:0]  char_clks
);
    logic [BITS_W-1:0] frame_bits;
    logic [CNT_W-1:0]  per_bit;
    logic [CNT_W-1:0]  raw;

    always_comb begin
        frame_bits = BITS_W'(9) - BITS_W'(short_chr) + BITS_W'(parity_on)
                   + BITS_W'(two_stop);
        per_bit    = CNT_W'(rate) << UNIT_SHIFT;
        raw        = (CNT_W'(frame_bits) * per_bit) << {div_sel, 1'b0};
        char_clks  = (rate == '0) ? CNT_W'(1) : raw;
    end
endmodule

// File: rtl/ctg_span.sv
module ctg_span
    import ctg_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic             expire
);
    span_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SPAN_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (start)                       cnt_q <= len - CNT_W'(1);
        else if (state_q == SPAN_RUN && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SPAN_IDLE: if (start) state_d = SPAN_RUN;
            SPAN_RUN: begin
                if (start)             state_d = SPAN_RUN;
                else if (cnt_q == '0)  state_d = SPAN_IDLE;
            end
            default: state_d = SPAN_IDLE;
        endcase
    end

    always_comb begin
        busy   = (state_q == SPAN_RUN);
        expire = (state_q == SPAN_RUN) && (cnt_q == '0);
    end

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && (cnt_q == $past(len) - CNT_W'(1)));
    p_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && cnt_q != '0) |=> busy && (cnt_q == $past(cnt_q) - CNT_W'(1)));
    p_idle_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !busy);
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !expire);
endmodule

// File: rtl/char_time_gen.sv
module char_time_gen
    import ctg_pkg::*;
#(
    parameter int RATE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              mode_short,
    input  logic              mode_parity,
    input  logic              mode_two_stop,
    input  logic [SEL_W-1:0]  clk_div_sel,
    input  logic [RATE_W-1:0] bit_rate,
    input  logic              tx_start,
    input  logic              rx_start,
    output logic              tx_char_end,
    output logic              rx_ready
);
    localparam int CNT_W = BITS_W + UNIT_SHIFT + RATE_W + 2 * ((1 << SEL_W) - 1);
    localparam int NSPAN = 2;

    logic              cfg_short_q, cfg_par_q, cfg_stop_q;
    logic [SEL_W-1:0]  cfg_sel_q;
    logic [RATE_W-1:0] cfg_rate_q;
    logic [CNT_W-1:0]  char_time;
    logic [NSPAN-1:0]  span_start, span_busy, span_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_short_q <= 1'b0;
            cfg_par_q   <= 1'b0;
            cfg_stop_q  <= 1'b0;
            cfg_sel_q   <= '0;
            cfg_rate_q  <= '1;
        end else if (cfg_load) begin
            cfg_short_q <= mode_short;
            cfg_par_q   <= mode_parity;
            cfg_stop_q  <= mode_two_stop;
            cfg_sel_q   <= clk_div_sel;
            cfg_rate_q  <= bit_rate;
        end
    end

    ctg_char_calc #(.RATE_W(RATE_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_calc (
        .short_chr (cfg_short_q),
        .parity_on (cfg_par_q),
        .two_stop  (cfg_stop_q),
        .div_sel   (cfg_sel_q),
        .rate      (cfg_rate_q),
        .char_clks (char_time)
    );

    assign span_start = {rx_start, tx_start};

    for (genvar g = 0; g < NSPAN; g++) begin : g_span
        ctg_span #(.CNT_W(CNT_W)) u_span (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (span_start[g]),
            .len    (char_time),
            .busy   (span_busy[g]),
            .expire (span_end[g])
        );
    end

    assign tx_char_end = span_end[0];
    assign rx_ready    = ~span_busy[1];

    p_hold_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(char_time));
    p_zero_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rate_q == '0) |-> (char_time == CNT_W'(1)));
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rate_q != '0) |-> (char_time >= (CNT_W'(cfg_rate_q) << UNIT_SHIFT)));
endmodule

// File: tb/sim_char_time_gen.sv
module sim_char_time_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic       mode_short = 1'b0, mode_parity = 1'b0, mode_two_stop = 1'b0;
    logic [1:0] clk_div_sel = '0;
    logic [7:0] bit_rate = '0;
    logic       tx_start = 1'b0, rx_start = 1'b0;
    logic       tx_char_end, rx_ready;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    char_time_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .mode_short(mode_short), .mode_parity(mode_parity),
        .mode_two_stop(mode_two_stop), .clk_div_sel(clk_div_sel),
        .bit_rate(bit_rate), .tx_start(tx_start), .rx_start(rx_start),
        .tx_char_end(tx_char_end), .rx_ready(rx_ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_cfg(input bit s, input bit p, input bit t,
                            input logic [1:0] sel, input logic [7:0] r);
        mode_short = s; mode_parity = p; mode_two_stop = t;
        clk_div_sel = sel; bit_rate = r; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        @(negedge clk);
    endtask

    task automatic tx_measure(input int t, input string tag);
        int n;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        n = 1;
        while (!tx_char_end && n < t + 4) begin
            @(negedge clk);
            n++;
        end
        check(tx_char_end && n == t, tag, n, t);
        @(negedge clk);
        check(!tx_char_end, {tag, " single pulse"}, int'(tx_char_end), 0);
    endtask

    task automatic rx_measure(input int t, input string tag);
        int n;
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        n = 1;
        while (!rx_ready && n < t + 4) begin
            @(negedge clk);
            n++;
        end
        check(rx_ready && n == t + 1, tag, n, t + 1);
    endtask

    task automatic t_reset;
        check(rx_ready == 1'b1, "R9 rx_ready after reset", int'(rx_ready), 1);
        check(tx_char_end == 1'b0, "R9 tx_char_end after reset", int'(tx_char_end), 0);
        rx_measure(73440, "R9 default time via rx R6");
    endtask

    task automatic t_shapes;
        load_cfg(1, 0, 0, 2'd0, 8'd1);
        tx_measure(256, "R1 R4 short char rate1");
        load_cfg(0, 1, 1, 2'd0, 8'd2);
        tx_measure(704, "R1 parity two-stop rate2");
        load_cfg(0, 0, 0, 2'd1, 8'd1);
        tx_measure(1152, "R2 prescale 4");
        load_cfg(1, 0, 0, 2'd3, 8'd1);
        tx_measure(16384, "R2 prescale 64");
        load_cfg(1, 1, 0, 2'd2, 8'd3);
        tx_measure(13824, "R2 prescale 16 rate3");
    endtask

    task automatic t_no_load;
        load_cfg(1, 0, 0, 2'd0, 8'd1);
        mode_short = 1'b0; bit_rate = 8'd5; clk_div_sel = 2'd2;
        @(negedge clk);
        tx_measure(256, "R3 inputs without load ignored");
    endtask

    task automatic t_zero_rate;
        load_cfg(0, 0, 0, 2'd3, 8'd0);
        tx_measure(1, "R7 zero rate one clock");
        rx_measure(1, "R7 zero rate rx");
    endtask

    task automatic t_restart;
        bit early = 1'b0;
        load_cfg(1, 0, 0, 2'd0, 8'd1);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        for (int i = 1; i < 100; i++) begin
            if (tx_char_end) early = 1'b1;
            @(negedge clk);
        end
        check(!early, "R5 no pulse before restart", int'(early), 0);
        tx_measure(256, "R5 restart full time");
    endtask

    task automatic t_overlap;
        int n_tx = 0;
        int n_rx = 0;
        load_cfg(1, 0, 0, 2'd0, 8'd1);
        tx_start = 1'b1; rx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0; rx_start = 1'b0;
        for (int n = 1; n <= 262; n++) begin
            if (tx_char_end && n_tx == 0) n_tx = n;
            if (rx_ready && n_rx == 0) n_rx = n;
            @(negedge clk);
        end
        check(n_tx == 256, "R8 tx end with rx running", n_tx, 256);
        check(n_rx == 257, "R8 R6 rx ready with tx running", n_rx, 257);
    endtask

    task automatic t_mid_run_cfg;
        int n;
        load_cfg(1, 0, 0, 2'd0, 8'd1);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        n = 1;
        mode_short = 1'b1; mode_parity = 1'b0; mode_two_stop = 1'b0;
        clk_div_sel = 2'd0; bit_rate = 8'd2; cfg_load = 1'b1;
        @(negedge clk);
        n++;
        cfg_load = 1'b0;
        while (!tx_char_end && n < 600) begin
            @(negedge clk);
            n++;
        end
        check(n == 256, "R10 run keeps old time", n, 256);
        @(negedge clk);
        tx_measure(512, "R10 new time on next start");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shapes();
        t_no_load();
        t_zero_rate();
        t_restart();
        t_overlap();
        t_mid_run_cfg();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule